// File: doc/BRIEF.md
# Synchronous Answer-to-Reset Responder

This block gives a serial memory device the smart-card style synchronous answer-to-reset. A card-side reset pulse that has at least one card-clock rising edge inside it arms the block. When the reset level drops, the block drives the first bit of a fixed response word onto a serial data output. Each later falling edge of the card clock moves the output to the next bit. Once the last bit has been clocked out, the block goes back to standby and releases the line.

The reset/clock overlap is judged again on every pulse. A pulse with a clock inside it restarts the response from its first bit, even while a response is running. A pulse with no clock inside it sends the block to standby. While the nonvolatile write controller reports a write in progress, every reset pulse is disregarded. A low power-good level clears the block to standby at once, without waiting for a clock.

The card reset and card clock are asynchronous to the system clock. They pass through a synchronizer whose depth is a parameter, and the block reacts to their edges in the system-clock domain. The response word is a parameter. Its most significant byte is sent first, and each byte goes out least significant bit first.

Top module: `aar_responder`

## Requirements
- R1: In standby the output-enable `aar_oe_o` is low and `aar_sdo_o` is held low. The block is in standby after power-good rises.
- R2: A card reset pulse that contains at least one card-clock rising edge starts a response when the reset falls. After that fall, `aar_oe_o` is high and the first response bit is on `aar_sdo_o`.
- R3: Bit order is as follows. Bytes go out from `RESP_WORD[31:24]` down to `RESP_WORD[7:0]`, and each byte goes out bit 0 first. The default word is 32'h1941AA55, so 0x19 is sent first and its LSB (1) is the first bit.
- R4: While a response runs and the card reset is low, each card-clock falling edge presents the next bit. The falling edge that follows the last bit returns the block to standby.
- R5: In standby, a reset pulse with no card-clock rising edge inside it leaves the block in standby.
- R6: During a response, a reset pulse with a card-clock rising edge inside it restarts the response from the first bit.
- R7: During a response, a reset pulse with no card-clock rising edge inside it aborts the response, and the block enters standby.
- R8: While `nv_busy_i` is high at the reset fall, the pulse is ignored. It neither starts nor restarts a response, and it does not abort a running one.
- R9: A low `pwr_ok_i` clears the block to standby asynchronously. The response does not resume when power-good returns.
- R10: Card-clock pulses in standby, with the card reset low, leave the output disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| pwr_ok_i | input | 1 | Power-good, active high; low is an asynchronous clear |
| card_rst_i | input | 1 | Card-side reset level, asynchronous |
| card_clk_i | input | 1 | Card-side clock level, asynchronous |
| nv_busy_i | input | 1 | High while a nonvolatile write is in progress |
| aar_sdo_o | output | 1 | Serial response bit, low when disabled |
| aar_oe_o | output | 1 | Output-enable for the serial data pad |

## Verification
The bench builds the block with its defaults: a 32-bit word of 32'h1941AA55 and a two-stage synchronizer. At these values every byte and every bit position of the default answer can be read back at the pins, so the byte order and the per-byte LSB-first order are both checked. The bench holds each card-side level for eight system clocks, which is longer than the synchronizer and edge-detector latency. A read therefore always finds the settled response, and the reset/clock overlap decisions are judged only on pin behaviour. With the 32-bit length, restart, abort and busy pulses can be placed at early, middle and late bit positions, and the final bit-to-standby step is reached on every full readout.

// File: rtl/aar_pkg.sv
package aar_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_SEND = 1'b1
   } aar_state_e;

   // Word bit index holding response bit i: bytes from the top down, LSB first in a byte.
   function automatic int unsigned aar_bit_pos(input int unsigned idx, input int unsigned width);
      return (width - 8) - 8 * (idx / 8) + (idx % 8);
   endfunction

endpackage

// File: rtl/aar_sync.sv
module aar_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk_i,
   input  logic             clr_n_i,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   if (STAGES > 4) begin : g_bad_depth
      $error("aar_sync: STAGES must be 0..4");
   end

   if (STAGES == 0) begin : g_bypass
      assign sync_o = async_i;
   end else begin : g_chain
      logic [WIDTH-1:0] stage_q [STAGES];
      always_ff @(posedge clk_i or negedge clr_n_i) begin
         if (!clr_n_i) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
         end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
         end
      end
      assign sync_o = stage_q[STAGES-1];
   end

endmodule

// File: rtl/aar_edge.sv
module aar_edge #(
   parameter int unsigned WIDTH = 2
) (
   input  logic             clk_i,
   input  logic             clr_n_i,
   input  logic [WIDTH-1:0] lvl_i,
   output logic [WIDTH-1:0] rise_o,
   output logic [WIDTH-1:0] fall_o
);

   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk_i or negedge clr_n_i) begin
      if (!clr_n_i) prev_q <= '0;
      else          prev_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~prev_q;
   assign fall_o = prev_q & ~lvl_i;

endmodule

// File: rtl/aar_seq.sv
module aar_seq
   import aar_pkg::*;
#(
   parameter int unsigned WORD_W = 32,
   localparam int unsigned IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
   input  logic             clk_i,
   input  logic             clr_n_i,
   input  logic             rst_lvl_i,
   input  logic             rst_rise_i,
   input  logic             rst_fall_i,
   input  logic             ck_rise_i,
   input  logic             ck_fall_i,
   input  logic             busy_i,
   output logic             send_o,
   output logic [IDX_W-1:0] idx_o
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

   aar_state_e       state_q;
   logic [IDX_W-1:0] idx_q;
   logic             armed_q;
   logic             step_ok;

   // A card clock rising inside the reset-high window arms the next reset fall.
   always_ff @(posedge clk_i or negedge clr_n_i) begin
      if (!clr_n_i)                   armed_q <= 1'b0;
      else if (ck_rise_i && rst_lvl_i) armed_q <= 1'b1;
      else if (rst_rise_i || rst_fall_i) armed_q <= 1'b0;
   end

   assign step_ok = (state_q == ST_SEND) && ck_fall_i && !rst_lvl_i;

   always_ff @(posedge clk_i or negedge clr_n_i) begin
      if (!clr_n_i) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
      end else if (rst_fall_i && !busy_i) begin
         state_q <= armed_q ? ST_SEND : ST_IDLE;
         idx_q   <= '0;
      end else if (step_ok && !rst_fall_i) begin
         if (idx_q == LAST_IDX) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   assign send_o = (state_q == ST_SEND);
   assign idx_o  = idx_q;

   p_start_r2: assert property (@(posedge clk_i) disable iff (!clr_n_i)
      (rst_fall_i && armed_q && !busy_i) |=> (send_o && idx_o == '0));

   p_abort_r7: assert property (@(posedge clk_i) disable iff (!clr_n_i)
      (rst_fall_i && !armed_q && !busy_i) |=> !send_o);

   p_busy_hold_r8: assert property (@(posedge clk_i) disable iff (!clr_n_i)
      (rst_fall_i && busy_i && !ck_fall_i) |=> ($stable(send_o) && $stable(idx_o)));

   p_advance_r4: assert property (@(posedge clk_i) disable iff (!clr_n_i)
      (send_o && ck_fall_i && !rst_lvl_i && !rst_fall_i && idx_o != LAST_IDX)
      |=> (send_o && idx_o == $past(idx_o) + 1'b1));

   p_finish_r4: assert property (@(posedge clk_i) disable iff (!clr_n_i)
      (send_o && ck_fall_i && !rst_lvl_i && !rst_fall_i && idx_o == LAST_IDX) |=> !send_o);

   p_idle_clk_r10: assert property (@(posedge clk_i) disable iff (!clr_n_i)
      (!send_o && !rst_fall_i) |=> !send_o);

endmodule

// File: rtl/aar_responder.sv
module aar_responder
   import aar_pkg::*;
#(
   parameter int unsigned         WORD_W      = 32,
   parameter logic [WORD_W-1:0]   RESP_WORD   = 32'h1941AA55,
   parameter int unsigned         SYNC_STAGES = 2,
   localparam int unsigned        IDX_W       = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
   input  logic clk_i,
   input  logic pwr_ok_i,
   input  logic card_rst_i,
   input  logic card_clk_i,
   input  logic nv_busy_i,
   output logic aar_sdo_o,
   output logic aar_oe_o
);

   if (WORD_W < 8 || (WORD_W % 8) != 0) begin : g_bad_word
      $error("aar_responder: WORD_W must be a non-zero multiple of 8");
   end

   logic [1:0]       lvl_s, rise_s, fall_s;
   logic             send_s;
   logic [IDX_W-1:0] idx_s;
   logic [WORD_W-1:0] order_s;

   aar_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .clr_n_i (pwr_ok_i),
      .async_i ({card_rst_i, card_clk_i}),
      .sync_o  (lvl_s)
   );

   aar_edge #(.WIDTH(2)) u_edge (
      .clk_i   (clk_i),
      .clr_n_i (pwr_ok_i),
      .lvl_i   (lvl_s),
      .rise_o  (rise_s),
      .fall_o  (fall_s)
   );

   aar_seq #(.WORD_W(WORD_W)) u_seq (
      .clk_i      (clk_i),
      .clr_n_i    (pwr_ok_i),
      .rst_lvl_i  (lvl_s[1]),
      .rst_rise_i (rise_s[1]),
      .rst_fall_i (fall_s[1]),
      .ck_rise_i  (rise_s[0]),
      .ck_fall_i  (fall_s[0]),
      .busy_i     (nv_busy_i),
      .send_o     (send_s),
      .idx_o      (idx_s)
   );

   // Reorder the word once into transmit order so the output is a plain index.
   for (genvar i = 0; i < WORD_W; i++) begin : g_order
      assign order_s[i] = RESP_WORD[aar_bit_pos(i, WORD_W)];
   end

   assign aar_oe_o  = send_s;
   assign aar_sdo_o = send_s & order_s[idx_s];

   p_quiet_r1: assert property (@(posedge clk_i) disable iff (!pwr_ok_i)
      !aar_oe_o |-> !aar_sdo_o);

endmodule

// File: tb/aar_responder_tb_top.sv
module aar_responder_tb_top;

   logic clk = 1'b0;
   logic pwr_ok, card_rst, card_clk, nv_busy;
   logic sdo, oe;
   int   n_checks = 0;
   int   n_errors = 0;
   bit   done = 1'b0;

   localparam int HOLD = 8;
   logic [7:0] resp_bytes [4] = '{8'h19, 8'h41, 8'hAA, 8'h55};

   always #5 clk = ~clk;

   aar_responder dut_i (
      .clk_i      (clk),
      .pwr_ok_i   (pwr_ok),
      .card_rst_i (card_rst),
      .card_clk_i (card_clk),
      .nv_busy_i  (nv_busy),
      .aar_sdo_o  (sdo),
      .aar_oe_o   (oe)
   );

   function automatic logic exp_bit(input int i);
      return resp_bytes[i / 8][i % 8];
   endfunction

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic clk_pulse();
      card_clk = 1'b1; wait_n(HOLD);
      card_clk = 1'b0; wait_n(HOLD);
   endtask

   task automatic rst_pulse(input bit with_clk);
      card_rst = 1'b1; wait_n(HOLD);
      if (with_clk) clk_pulse();
      card_rst = 1'b0; wait_n(HOLD);
   endtask

   task automatic read_bits(input int first, input int count, input string req);
      for (int i = first; i < first + count; i++) begin
         chk({req, " oe"}, oe, 1'b1);
         chk({req, " bit"}, sdo, exp_bit(i));
         clk_pulse();
      end
   endtask

   task automatic t_reset();
      chk("R1 oe after power-up", oe, 1'b0);
      chk("R1 sdo after power-up", sdo, 1'b0);
   endtask

   task automatic t_full();
      rst_pulse(1);
      chk("R2 oe after start", oe, 1'b1);
      chk("R2 first bit", sdo, 1'b1);
      read_bits(0, 32, "R3");
      chk("R4 standby after last bit", oe, 1'b0);
      chk("R1 sdo low in standby", sdo, 1'b0);
   endtask

   task automatic t_no_clk_idle();
      rst_pulse(0);
      chk("R5 no start without clock", oe, 1'b0);
   endtask

   task automatic t_idle_clk();
      for (int k = 0; k < 3; k++) begin
         clk_pulse();
         chk("R10 idle clock", oe, 1'b0);
      end
   endtask

   task automatic t_restart();
      rst_pulse(1);
      read_bits(0, 5, "R6 pre");
      rst_pulse(1);
      chk("R6 restart bit0", sdo, exp_bit(0));
      read_bits(0, 32, "R6");
      chk("R6 standby after restarted run", oe, 1'b0);
   endtask

   task automatic t_abort();
      rst_pulse(1);
      read_bits(0, 7, "R7 pre");
      rst_pulse(0);
      chk("R7 abort oe", oe, 1'b0);
      chk("R7 abort sdo", sdo, 1'b0);
      clk_pulse();
      chk("R7 stays in standby", oe, 1'b0);
   endtask

   task automatic t_busy();
      nv_busy = 1'b1;
      rst_pulse(1);
      chk("R8 no start while busy", oe, 1'b0);
      nv_busy = 1'b0;
      rst_pulse(1);
      read_bits(0, 3, "R8 pre");
      nv_busy = 1'b1;
      rst_pulse(0);
      chk("R8 abort ignored oe", oe, 1'b1);
      chk("R8 abort ignored bit", sdo, exp_bit(3));
      rst_pulse(1);
      chk("R8 restart ignored bit", sdo, exp_bit(3));
      nv_busy = 1'b0;
      read_bits(3, 29, "R8 resume");
      chk("R8 standby at end", oe, 1'b0);
   endtask

   task automatic t_power();
      rst_pulse(1);
      read_bits(0, 10, "R9 pre");
      pwr_ok = 1'b0; wait_n(2);
      chk("R9 cleared oe", oe, 1'b0);
      chk("R9 cleared sdo", sdo, 1'b0);
      pwr_ok = 1'b1; wait_n(HOLD);
      clk_pulse();
      chk("R9 no resume", oe, 1'b0);
   endtask

   initial begin
      pwr_ok = 1'b0; card_rst = 1'b0; card_clk = 1'b0; nv_busy = 1'b0;
      wait_n(4);
      pwr_ok = 1'b1;
      wait_n(HOLD);
      t_reset();
      t_full();
      t_no_clk_idle();
      t_idle_clk();
      t_restart();
      t_abort();
      t_busy();
      t_power();
      t_full();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
         $finish;
      end
   end

endmodule